// File: doc/BRIEF.md
# Smart Card Character Receiver with Convention Detection

This block receives asynchronous characters arriving on the card's single bidirectional data line. Each character is ten bit periods long: a low start bit, eight data bits and an even parity bit. Timing comes from a card-clock tick input. One bit period is a parameterised number of ticks, 372 by default. A falling edge is taken as a start candidate, and it is confirmed half a bit period later. Every further bit is sampled at the centre of its period.

The receiver does not assume a fixed framing. The first character after reset or rearm is compared against the two initial-character line patterns. That comparison sets both the logic polarity and the bit order for all later characters. The initial character itself is passed on as a decoded byte, so that the answer-to-reset logic upstream sees it like any other byte. A first character that matches neither pattern raises a flag, and the receiver stays undecided.

Top module: `sc_char_rx`

## Requirements
- R1: A character starts only on a high-to-low transition of `io_line` while idle, and only if the line is still low half a bit period later; a shorter low pulse produces no byte.
- R2: After the start check, the nine remaining bits are sampled every `ETU_CYCLES` asserted `card_tick` cycles; cycles without `card_tick` do not advance the timing.
- R3: While undecided, the line levels 1,1,0,1,1,1,0,0,1 (first bit after start first) set `conv_known`=1 and `conv_inverse`=0, and deliver byte 0x3B with `parity_err`=0.
- R4: While undecided, the levels 1,1,0,0,0,0,0,0,1 set `conv_known`=1 and `conv_inverse`=1, and deliver byte 0x3F with `parity_err`=0.
- R5: While undecided, any other character sets `ts_invalid`=1, delivers no byte and leaves `conv_known`=0.
- R6: In the direct convention a high level is 1, and the first data bit is bit 0 of `rx_data`.
- R7: In the inverse convention a low level is 1, the first data bit is bit 7 of `rx_data`, and the parity level is also inverted.
- R8: `parity_err` is high together with `rx_valid` when the decoded data and parity bits hold an odd number of ones; the byte is still delivered.
- R9: Once a convention is decided, it is kept until rearm, even if a later character matches an initial-character pattern.
- R10: `rearm` clears `conv_known`, `conv_inverse` and `ts_invalid` and abandons any character in progress; `rx_valid` is a single-cycle strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rearm | input | 1 | Forget convention and wait for a new initial character |
| card_tick | input | 1 | One pulse per card clock cycle |
| io_line | input | 1 | Synchronised level of the card data line |
| rx_data | output | 8 | Decoded byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| parity_err | output | 1 | Parity failure of the strobed byte |
| conv_known | output | 1 | A convention has been decided |
| conv_inverse | output | 1 | Decided convention is inverse |
| ts_invalid | output | 1 | Last undecided character matched no pattern |

## Verification
The hardest situation to reach from the ports is a character that, once a convention has been decided, looks exactly like an initial character. The receiver must decode it as ordinary data and must not switch convention. The bench drives the inverse-convention initial pattern while the receiver is in the direct convention, and drives the reverse case as well. For each case it computes the odd-parity byte that should come out. A rearm in the middle of a character and a sub-half-bit glitch on the line are also driven, to check that no stray byte appears.

// File: rtl/sc_rx_pkg.sv
// Shared types, initial-character patterns and the convention decode function.
// Assumes raw[0] is the first bit after the start bit and raw[8] the parity level.
package sc_rx_pkg;

    typedef enum logic [1:0] {FR_IDLE, FR_START, FR_DATA} fr_state_t;

    typedef struct packed {
        logic [7:0] data;
        logic       perr;
    } dec_t;

    // Raw level patterns of the two initial characters, first bit in raw[0].
    localparam logic [8:0] PAT_DIRECT  = 9'b100111011;
    localparam logic [8:0] PAT_INVERSE = 9'b100000011;
    localparam logic [7:0] BYTE_DIRECT  = 8'h3B;
    localparam logic [7:0] BYTE_INVERSE = 8'h3F;

    // Apply a convention to nine raw levels and compute the parity verdict.
    function automatic dec_t conv_decode(input logic [8:0] raw, input logic inv);
        dec_t r;
        logic par;
        for (int i = 0; i < 8; i++) begin
            if (inv) r.data[7-i] = ~raw[i];
            else     r.data[i]   = raw[i];
        end
        par    = inv ? ~raw[8] : raw[8];
        r.perr = ^{r.data, par};
        return r;
    endfunction

endpackage

// File: rtl/sc_etu_timer.sv
// Bit-period timer: counts card ticks and pulses `expire` on the tick that
// ends either a half or a full bit period. Assumes ETU_CYCLES >= 2.
module sc_etu_timer #(
    parameter int ETU_CYCLES = 372
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    input  logic half,
    output logic expire
);
    localparam int CW   = $clog2(ETU_CYCLES + 1);
    localparam int HALF = ETU_CYCLES / 2;
    localparam logic [CW-1:0] FULL_LAST = CW'(ETU_CYCLES - 1);
    localparam logic [CW-1:0] HALF_LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt;

    // Expiry is the last tick of the selected interval.
    assign expire = tick && (cnt == (half ? HALF_LAST : FULL_LAST));

    // Tick counter, restarting on clear or expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (clear)  cnt <= '0;
        else if (expire) cnt <= '0;
        else if (tick)   cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sc_frame_rx.sv
// Character framer: detects a falling edge, confirms the start bit at mid-bit,
// then samples nine bits at their centres. Delivers the raw levels with `done`.
// Assumes io is already synchronised to clk.
module sc_frame_rx
    import sc_rx_pkg::*;
#(
    parameter int ETU_CYCLES = 372,
    parameter int NBITS      = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             abort,
    input  logic             tick,
    input  logic             io,
    output logic [NBITS-1:0] raw,
    output logic             done
);
    localparam int IW = $clog2(NBITS);

    fr_state_t      state;
    logic           prev_io;
    logic [IW-1:0]  idx;
    logic           expire;

    sc_etu_timer #(.ETU_CYCLES(ETU_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  ((state == FR_IDLE) || abort),
        .tick   (tick),
        .half   (state == FR_START),
        .expire (expire)
    );

    // Frame state machine with bit shift-in, first bit ends in raw[0].
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= FR_IDLE;
            prev_io <= 1'b1;
            idx     <= '0;
            raw     <= '0;
            done    <= 1'b0;
        end else begin
            prev_io <= io;
            done    <= 1'b0;
            if (abort) begin
                state <= FR_IDLE;
            end else begin
                case (state)
                    FR_IDLE: if (prev_io && !io) state <= FR_START;
                    FR_START: if (expire) begin
                        state <= io ? FR_IDLE : FR_DATA;
                        idx   <= '0;
                    end
                    FR_DATA: if (expire) begin
                        raw <= {io, raw[NBITS-1:1]};
                        if (idx == IW'(NBITS - 1)) begin
                            done  <= 1'b1;
                            state <= FR_IDLE;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                    default: state <= FR_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/sc_conv_latch.sv
// Convention decider and byte decoder: while undecided, matches each character
// against the two initial patterns; once decided, decodes every character.
// Assumes `done` is a single-cycle pulse with `raw` valid at the same time.
module sc_conv_latch
    import sc_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rearm,
    input  logic       done,
    input  logic [8:0] raw,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    output logic       parity_err,
    output logic       conv_known,
    output logic       conv_inverse,
    output logic       ts_invalid
);
    dec_t dec;

    // Decode with the currently latched convention.
    always_comb dec = conv_decode(raw, conv_inverse);

    // Convention latch and registered byte output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data      <= '0;
            rx_valid     <= 1'b0;
            parity_err   <= 1'b0;
            conv_known   <= 1'b0;
            conv_inverse <= 1'b0;
            ts_invalid   <= 1'b0;
        end else begin
            rx_valid   <= 1'b0;
            parity_err <= 1'b0;
            if (rearm) begin
                conv_known   <= 1'b0;
                conv_inverse <= 1'b0;
                ts_invalid   <= 1'b0;
            end else if (done) begin
                if (conv_known) begin
                    rx_data    <= dec.data;
                    parity_err <= dec.perr;
                    rx_valid   <= 1'b1;
                end else if (raw == PAT_DIRECT || raw == PAT_INVERSE) begin
                    conv_known   <= 1'b1;
                    conv_inverse <= (raw == PAT_INVERSE);
                    ts_invalid   <= 1'b0;
                    rx_data      <= (raw == PAT_INVERSE) ? BYTE_INVERSE : BYTE_DIRECT;
                    rx_valid     <= 1'b1;
                end else begin
                    ts_invalid <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sc_char_rx.sv
// Top: smart card character receiver that learns polarity and bit order
// from the initial character. Assumes io_line is synchronised to clk and
// card_tick pulses once per card clock cycle.
module sc_char_rx #(
    parameter int ETU_CYCLES = 372
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rearm,
    input  logic       card_tick,
    input  logic       io_line,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    output logic       parity_err,
    output logic       conv_known,
    output logic       conv_inverse,
    output logic       ts_invalid
);
    logic [8:0] raw;
    logic       done;

    sc_frame_rx #(.ETU_CYCLES(ETU_CYCLES), .NBITS(9)) u_frame (
        .clk   (clk),
        .rst_n (rst_n),
        .abort (rearm),
        .tick  (card_tick),
        .io    (io_line),
        .raw   (raw),
        .done  (done)
    );

    sc_conv_latch u_conv (
        .clk          (clk),
        .rst_n        (rst_n),
        .rearm        (rearm),
        .done         (done),
        .raw          (raw),
        .rx_data      (rx_data),
        .rx_valid     (rx_valid),
        .parity_err   (parity_err),
        .conv_known   (conv_known),
        .conv_inverse (conv_inverse),
        .ts_invalid   (ts_invalid)
    );
endmodule

// File: rtl/sc_char_rx_chk.sv
// Property checker for sc_char_rx, attached by bind; observes ports only.
module sc_char_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic rearm,
    input logic rx_valid,
    input logic parity_err,
    input logic conv_known,
    input logic conv_inverse,
    input logic ts_invalid
);
    // R10
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    // R10
    rearm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rearm |=> (!conv_known && !conv_inverse && !ts_invalid && !rx_valid));
    // R9
    conv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_known && !rearm) |=> (conv_known && $stable(conv_inverse)));
    // R5
    invalid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ts_invalid && conv_known));
    // R3
    valid_needs_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> conv_known);
    // R8
    perr_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        parity_err |-> rx_valid);
endmodule

bind sc_char_rx sc_char_rx_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rearm        (rearm),
    .rx_valid     (rx_valid),
    .parity_err   (parity_err),
    .conv_known   (conv_known),
    .conv_inverse (conv_inverse),
    .ts_invalid   (ts_invalid)
);

// File: tb/sc_char_rx_bench.sv
// Scoreboard bench: the driver pushes expected bytes, the monitor pops on rx_valid.
module sc_char_rx_bench;
    localparam int ETU = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rearm = 1'b0;
    logic       io_line = 1'b1;
    logic [7:0] rx_data;
    logic       rx_valid, parity_err, conv_known, conv_inverse, ts_invalid;
    logic       card_tick;
    int         tick_div = 1;
    int         tcnt = 0;
    int         checks = 0;
    int         errors = 0;
    bit         done_flag = 0;
    logic [8:0] exp_q[$];   // {parity_err, data}

    always #5 clk = ~clk;

    // Card tick generator, one pulse every tick_div clocks.
    always @(posedge clk) tcnt <= (tcnt >= tick_div - 1) ? 0 : tcnt + 1;
    assign card_tick = (tcnt == 0);

    sc_char_rx #(.ETU_CYCLES(ETU)) u_sc_char_rx (
        .clk(clk), .rst_n(rst_n), .rearm(rearm), .card_tick(card_tick),
        .io_line(io_line), .rx_data(rx_data), .rx_valid(rx_valid),
        .parity_err(parity_err), .conv_known(conv_known),
        .conv_inverse(conv_inverse), .ts_invalid(ts_invalid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Line levels of a byte under a convention, optionally with wrong parity.
    function automatic logic [8:0] encode(input logic [7:0] b, input bit inv, input bit bad);
        logic [8:0] r;
        logic p;
        p = (^b) ^ bad;
        for (int i = 0; i < 8; i++) r[i] = inv ? ~b[7-i] : b[i];
        r[8] = inv ? ~p : p;
        return r;
    endfunction

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_raw(input logic [8:0] r);
        int bc;
        bc = ETU * tick_div;
        io_line = 1'b0;
        hold(bc);
        for (int i = 0; i < 9; i++) begin
            io_line = r[i];
            hold(bc);
        end
        io_line = 1'b1;
        hold(3 * bc);
    endtask

    task automatic expect_byte(input logic [7:0] b, input bit perr);
        exp_q.push_back({perr, b});
    endtask

    // Monitor: compare every strobed byte against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (exp_q.size() == 0) begin
                check(0, "R1/R5 unexpected byte", {parity_err, rx_data}, 0);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                check({parity_err, rx_data} == e, "R6/R7/R8 byte", {parity_err, rx_data}, e);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        hold(4);
        rst_n = 1'b1;
        hold(2);
        // reset state (R10)
        check(!rx_valid && !conv_known && !ts_invalid, "R10 reset state",
              {rx_valid, conv_known, ts_invalid}, 0);

        // R5: unmatched first character
        send_raw(9'b010101010);
        check(ts_invalid == 1'b1, "R5 ts_invalid", ts_invalid, 1);
        check(conv_known == 1'b0, "R5 conv_known", conv_known, 0);

        // R1: glitch shorter than half a bit must not start a character
        io_line = 1'b0; hold(3); io_line = 1'b1; hold(4 * ETU);

        // R3: direct initial character
        expect_byte(8'h3B, 0);
        send_raw(sc_rx_pkg::PAT_DIRECT);
        check(conv_known && !conv_inverse, "R3 direct latched", {conv_known, conv_inverse}, 2);
        check(ts_invalid == 1'b0, "R3 ts_invalid cleared", ts_invalid, 0);

        // R6 direct data, R8 parity error
        expect_byte(8'hA5, 0); send_raw(encode(8'hA5, 0, 0));
        expect_byte(8'h01, 0); send_raw(encode(8'h01, 0, 0));
        expect_byte(8'h80, 1); send_raw(encode(8'h80, 0, 1));

        // R9: inverse initial pattern while direct decodes as 0x03 with odd parity
        expect_byte(8'h03, 1);
        send_raw(sc_rx_pkg::PAT_INVERSE);
        check(conv_known && !conv_inverse, "R9 direct kept", {conv_known, conv_inverse}, 2);

        // R2: slower card tick stretches the bit period
        tick_div = 2; hold(4);
        expect_byte(8'h5A, 0); send_raw(encode(8'h5A, 0, 0));
        tick_div = 1; hold(4);

        // R10: rearm in the middle of a character
        io_line = 1'b0; hold(3 * ETU);
        rearm = 1'b1; hold(1); rearm = 1'b0;
        io_line = 1'b1; hold(12 * ETU);
        check(!conv_known && !conv_inverse && !ts_invalid, "R10 rearm clears",
              {conv_known, conv_inverse, ts_invalid}, 0);

        // R4: inverse initial character
        expect_byte(8'h3F, 0);
        send_raw(sc_rx_pkg::PAT_INVERSE);
        check(conv_known && conv_inverse, "R4 inverse latched", {conv_known, conv_inverse}, 3);

        // R7 inverse data, R8 parity error
        expect_byte(8'h01, 0); send_raw(encode(8'h01, 1, 0));
        expect_byte(8'h80, 0); send_raw(encode(8'h80, 1, 0));
        expect_byte(8'hC3, 1); send_raw(encode(8'hC3, 1, 1));

        // R9: direct initial pattern while inverse decodes as 0x23 with odd parity
        expect_byte(8'h23, 1);
        send_raw(sc_rx_pkg::PAT_DIRECT);
        check(conv_known && conv_inverse, "R9 inverse kept", {conv_known, conv_inverse}, 3);

        hold(4);
        check(exp_q.size() == 0, "R8 missing bytes", exp_q.size(), 0);
        done_flag = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule